// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a synchronous pipelined burst SRAM with a word made of byte lanes. Each lane is 9 bits wide: 8 data bits and 1 parity bit. The array is small and its depth is a parameter. All commands are sampled on the rising clock edge.

Accesses start through one of two address strobes:
- The processor strobe is only recognised when the first active-low chip enable is low.
- The controller strobe is recognised on its own.

Between strobes, an advance input steps a 2-bit burst counter through a four-word group, in either linear or exclusive-or order. When advance is inactive the burst is held on the current word.

Read data passes through an address stage and an output register. It appears on the bus one edge after the edge that issued the read. Write data is captured in an input register on the sampling edge and committed on the following edge. Output enable and a sleep input act on the bus without a clock. The bidirectional data bus is split into an input port, an output port and a drive-enable port, which the surrounding pad logic combines.

Top module: `pbs_sram`

## Requirements
- R1: A read issued on edge k drives `dq_oe` high and the stored word on `dq_out` after edge k+1. This requires `oe_n` low and `sleep` low.
- R2: A controller-strobe edge writes in that same cycle when three things hold: the chips are selected, the processor strobe is not recognised, and a lane is chosen. A controller-strobe read of the same address on the next edge returns the new word.
- R3: On a processor-strobe edge the write controls are ignored and a read of the presented address is issued. The write controls and `dq_in` are taken on the next edge, when both strobes are high.
- R4: `gw_n` low writes every lane, whatever `bwe_n` and `be_n` hold.
- R5: With `gw_n` high and `bwe_n` low, each `be_n[i]` low writes lane i, which is bits [9i+8:9i]. `bwe_n` high, or `be_n` all high, makes the cycle a read that changes no stored word.
- R6: With both strobes high during an active burst, `adv_n` low steps the burst offset n from 0 up to 3 and then wraps. The low two address bits become (start+n) mod 4 when `lin_mode`=1 and start XOR n when `lin_mode`=0. The upper address bits are held.
- R7: With both strobes high during an active burst, `adv_n` high repeats the current address.
- R8: A recognised strobe with any chip enable inactive ends the burst. `dq_oe` is then low after the next edge, and later strobe-free cycles access nothing.
- R9: When `cs0_n` is high, the processor strobe is ignored. The cycle then behaves as a strobe-free cycle.
- R10: After an edge that selects the block from the deselected state, `dq_oe` stays low for that first cycle.
- R11: `oe_n` high forces `dq_oe` low without waiting for a clock edge.
- R12: `sleep` high forces `dq_oe` low without a clock and blocks every access. Stored words are kept.
- R13: When both strobes are low, only the processor strobe is acted on, so the write controls on that edge are ignored.
- R14: After reset, `dq_oe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs0_n | input | 1 | Chip enable, active low; gates the processor strobe |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low, has priority |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| lin_mode | input | 1 | Burst order: 1 linear, 0 exclusive-or |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Data from the bus |
| dq_out | output | LANES*LANE_W | Data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bound checker watches several properties on every cycle:
- the asynchronous high-impedance forcing by `oe_n` and `sleep`;
- the two-edge read-to-drive relation;
- the silent first cycle after selection;
- the bus release one edge after a deselect;
- the burst offset step and reload.

The other behaviours can only be shown by the directed scenarios, because they depend on the stored words:
- the stored word contents and lane merging;
- the ignored controls on a processor-strobe edge;
- the two burst orderings;
- the suspend repeat;
- read-after-write data;
- the survival of contents through sleep.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_ADD = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic load;   // strobe with chips selected: new burst base
        logic desel;  // strobe with a chip enable inactive
        logic cont;   // strobe-free cycle inside an active burst
        logic step;   // continue cycle that advances the offset
        logic rd;     // read issued on this edge
        logic wr;     // write captured on this edge
    } pbs_cmd_t;

    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] offs,
                                             input burst_order_e order);
        return (order == ORDER_ADD) ? 2'(start + offs) : (start ^ offs);
    endfunction

endpackage

// File: rtl/pbs_cmd_decode.sv
module pbs_cmd_decode
    import pbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             ads_proc_n,
    input  logic             ads_ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] be_n,
    input  logic             sleep,
    input  logic             active,
    output pbs_cmd_t         cmd,
    output logic [LANES-1:0] wr_lanes
);

    logic             sel_all;
    logic             proc_hit;
    logic             strobe;
    logic [LANES-1:0] lane_sel;
    logic             any_lane;

    always_comb begin
        sel_all  = ~cs0_n & cs1 & ~cs2_n;
        proc_hit = ~ads_proc_n & ~cs0_n;
        strobe   = proc_hit | ~ads_ctrl_n;
        if (!gw_n)
            lane_sel = '1;
        else if (!bwe_n)
            lane_sel = ~be_n;
        else
            lane_sel = '0;
        any_lane = |lane_sel;

        cmd = '0;
        if (!sleep) begin
            cmd.load  = strobe & sel_all;
            cmd.desel = strobe & ~sel_all;
            cmd.cont  = ~strobe & active;
            cmd.step  = cmd.cont & ~adv_n;
            cmd.wr    = ((cmd.load & ~proc_hit) | cmd.cont) & any_lane;
            cmd.rd    = (cmd.load & (proc_hit | ~any_lane)) | (cmd.cont & ~any_lane);
        end
        wr_lanes = cmd.wr ? lane_sel : '0;
    end

endmodule

// File: rtl/pbs_burst_ctr.sv
module pbs_burst_ctr
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  pbs_cmd_t          cmd,
    input  logic [ADDR_W-1:0] addr,
    input  burst_order_e      order,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active,
    output logic [1:0]        offs_q
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        offs_nxt;

    always_comb begin
        offs_nxt = cmd.step ? 2'(offs_q + 2'd1) : offs_q;
        if (cmd.load)
            acc_addr = addr;
        else
            acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], offs_nxt, order)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            offs_q <= '0;
            active <= 1'b0;
        end else if (cmd.load) begin
            base_q <= addr;
            offs_q <= '0;
            active <= 1'b1;
        end else if (cmd.desel) begin
            active <= 1'b0;
        end else begin
            offs_q <= offs_nxt;
        end
    end

endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_req,
    input  logic                    wr_req,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    out_vld
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic              wr_pend;
    logic              rd_pend;
    logic [ADDR_W-1:0] wr_a;
    logic [ADDR_W-1:0] rd_a;
    logic [LANES-1:0]  wr_m;
    logic [DATA_W-1:0] wr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            wr_pend <= wr_req;
            rd_pend <= rd_req;
            out_vld <= rd_pend;
        end
    end

    always_ff @(posedge clk) begin
        wr_a <= acc_addr;
        rd_a <= acc_addr;
        wr_m <= wr_lanes;
        wr_d <= din;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_pend && wr_m[g])
                bank[wr_a] <= wr_d[g*LANE_W +: LANE_W];
            if (rd_pend)
                q <= bank[rd_a];
        end

        assign dout[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/pbs_sram.sv
module pbs_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        be_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    lin_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    pbs_cmd_t          cmd;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] acc_addr;
    logic              active;
    logic [1:0]        burst_offs;
    logic              out_vld;
    burst_order_e      order;

    assign order = burst_order_e'(lin_mode);

    pbs_cmd_decode #(.LANES(LANES)) u_dec (
        .cs0_n      (cs0_n),
        .cs1        (cs1),
        .cs2_n      (cs2_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .be_n       (be_n),
        .sleep      (sleep),
        .active     (active),
        .cmd        (cmd),
        .wr_lanes   (wr_lanes)
    );

    pbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr     (addr),
        .order    (order),
        .acc_addr (acc_addr),
        .active   (active),
        .offs_q   (burst_offs)
    );

    pbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (cmd.rd),
        .wr_req   (cmd.wr),
        .wr_lanes (wr_lanes),
        .acc_addr (acc_addr),
        .din      (dq_in),
        .dout     (dq_out),
        .out_vld  (out_vld)
    );

    assign dq_oe = out_vld & ~oe_n & ~sleep;

endmodule

// File: rtl/pbs_sram_chk.sv
module pbs_sram_chk (
    input logic       clk,
    input logic       rst,
    input logic       oe_n,
    input logic       sleep,
    input logic       dq_oe,
    input logic       cmd_load,
    input logic       cmd_desel,
    input logic       cmd_rd,
    input logic       cmd_step,
    input logic       active,
    input logic [1:0] offs
);

    // R11
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R12
    sleep_release_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> ##1 (dq_oe || oe_n || sleep));

    // R8
    desel_release_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_desel |=> ##1 !dq_oe);

    // R10
    first_select_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && !active) |=> !dq_oe);

    // R6
    offs_step_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_step |=> (offs == 2'($past(offs) + 2'd1)));

    // R6
    offs_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_load |=> (offs == 2'd0 && active));

endmodule

bind pbs_sram pbs_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dq_oe     (dq_oe),
    .cmd_load  (cmd.load),
    .cmd_desel (cmd.desel),
    .cmd_rd    (cmd.rd),
    .cmd_step  (cmd.step),
    .active    (active),
    .offs      (burst_offs)
);

// File: tb/pbs_sram_tb.sv
module pbs_sram_tb;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs0_n, cs1, cs2_n;
    logic          ads_proc_n, ads_ctrl_n, adv_n;
    logic          gw_n, bwe_n;
    logic [NL-1:0] be_n;
    logic          oe_n, sleep, lin_mode;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    logic [DW-1:0] ref_mem [1 << AW];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    pbs_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .oe_n(oe_n), .sleep(sleep),
        .lin_mode(lin_mode), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'(64'(a) * 64'h9E3779B1 + 64'(s) * 64'h5851F42D + 64'd17);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; be_n = '1;
        oe_n = 1'b0; sleep = 1'b0;
    endtask

    task automatic ctrl_write(input int a, input logic [DW-1:0] d);
        idle();
        ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = AW'(a); dq_in = d;
        step();
        ref_mem[a] = d;
        idle();
    endtask

    task automatic read_check(input int a, input string tag);
        idle();
        ads_ctrl_n = 1'b0; addr = AW'(a);
        step();
        idle();
        step();
        chk({tag, " oe"}, DW'(dq_oe), DW'(1));
        chk({tag, " data"}, dq_out, ref_mem[a]);
    endtask

    // R14
    task automatic t_reset();
        idle();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R14 reset oe", DW'(dq_oe), DW'(0));
        step();
        chk("R14 no burst after reset", DW'(dq_oe), DW'(0));
    endtask

    // R2 R4 R1
    task automatic t_global_write();
        for (int a = 0; a < 16; a++) ctrl_write(a, pat(a, 1));
        idle();
        ads_ctrl_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; be_n = '1;
        addr = AW'(3); dq_in = pat(3, 2);
        step();
        ref_mem[3] = pat(3, 2);
        idle();
        read_check(3, "R4 global write ignores lane selects");
        read_check(7, "R1 read of stored word");
        idle();
        ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = AW'(5); dq_in = pat(5, 9);
        step();
        ref_mem[5] = pat(5, 9);
        read_check(5, "R2 read on next edge after write");
    endtask

    // R5
    task automatic t_byte_write();
        logic [DW-1:0] nw;
        logic [DW-1:0] exp;
        nw  = pat(6, 4);
        exp = ref_mem[6];
        idle();
        ads_ctrl_n = 1'b0; bwe_n = 1'b0; be_n = 4'b1010; addr = AW'(6); dq_in = nw;
        step();
        for (int i = 0; i < NL; i++)
            if (i == 0 || i == 2) exp[i*LW +: LW] = nw[i*LW +: LW];
        ref_mem[6] = exp;
        read_check(6, "R5 lanes 0 and 2 merged");
        idle();
        ads_ctrl_n = 1'b0; bwe_n = 1'b1; be_n = '0; addr = AW'(6); dq_in = pat(6, 5);
        step();
        idle();
        ads_ctrl_n = 1'b0; bwe_n = 1'b0; be_n = '1; addr = AW'(6); dq_in = pat(6, 6);
        step();
        read_check(6, "R5 no lane selected leaves word");
    endtask

    // R3 R13
    task automatic t_proc_write();
        logic [DW-1:0] old;
        old = ref_mem[10];
        idle();
        ads_proc_n = 1'b0; gw_n = 1'b0; addr = AW'(10); dq_in = pat(10, 7);
        step();
        idle();
        gw_n = 1'b0; dq_in = pat(10, 8);
        step();
        chk("R3 strobe edge issued a read oe", DW'(dq_oe), DW'(1));
        chk("R3 strobe edge read old word", dq_out, old);
        ref_mem[10] = pat(10, 8);
        read_check(10, "R3 second edge wrote");
        idle();
        ads_proc_n = 1'b0; ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = AW'(10); dq_in = pat(10, 11);
        step();
        idle();
        step();
        read_check(10, "R13 both strobes low no write");
    endtask

    task automatic burst_run(input int start, input bit lin, input logic [3:0] advs,
                             input int o0, input int o1, input int o2, input int o3,
                             input string tag);
        int exp_a [4];
        exp_a[0] = o0; exp_a[1] = o1; exp_a[2] = o2; exp_a[3] = o3;
        idle();
        lin_mode = lin;
        ads_ctrl_n = 1'b0; addr = AW'(start);
        step();
        for (int i = 0; i < 4; i++) begin
            idle();
            adv_n = advs[i];
            step();
            chk({tag, " oe"}, DW'(dq_oe), DW'(1));
            chk(tag, dq_out, ref_mem[exp_a[i]]);
        end
        idle();
    endtask

    // R6 R7
    task automatic t_burst();
        for (int a = 8; a < 12; a++) ctrl_write(a, pat(a, 20));
        burst_run(9, 1'b1, 4'b1000, 9, 10, 11, 8, "R6 linear order");
        burst_run(9, 1'b0, 4'b1000, 9, 8, 11, 10, "R6 xor order");
        burst_run(10, 1'b1, 4'b1010, 10, 11, 11, 8, "R7 suspend repeats");
    endtask

    // R8 R10
    task automatic t_deselect();
        idle();
        ads_ctrl_n = 1'b0; addr = AW'(2);
        step();
        idle();
        ads_ctrl_n = 1'b0; cs1 = 1'b0;
        step();
        chk("R8 last read still drives", dq_out, ref_mem[2]);
        idle();
        adv_n = 1'b0;
        step();
        chk("R8 released after deselect", DW'(dq_oe), DW'(0));
        step();
        chk("R8 no access while deselected", DW'(dq_oe), DW'(0));
        idle();
        ads_ctrl_n = 1'b0; addr = AW'(4);
        step();
        chk("R10 first selected cycle silent", DW'(dq_oe), DW'(0));
        idle();
        step();
        chk("R10 then drives", dq_out, ref_mem[4]);
        idle();
        ads_proc_n = 1'b0; cs2_n = 1'b1;
        step();
        idle();
        step();
        chk("R8 processor strobe deselect", DW'(dq_oe), DW'(0));
    endtask

    // R9
    task automatic t_proc_gated();
        idle();
        ads_ctrl_n = 1'b0; addr = AW'(12);
        step();
        idle();
        cs0_n = 1'b1; ads_proc_n = 1'b0; addr = AW'(13);
        step();
        idle();
        step();
        chk("R9 gated strobe keeps burst oe", DW'(dq_oe), DW'(1));
        chk("R9 gated strobe keeps address", dq_out, ref_mem[12]);
    endtask

    // R11 R12
    task automatic t_async();
        logic [DW-1:0] old;
        read_check(14, "R11 setup read");
        oe_n = 1'b1;
        #1;
        chk("R11 oe high releases", DW'(dq_oe), DW'(0));
        oe_n = 1'b0;
        #1;
        chk("R11 oe low drives again", DW'(dq_oe), DW'(1));
        sleep = 1'b1;
        #1;
        chk("R12 sleep releases", DW'(dq_oe), DW'(0));
        old = ref_mem[14];
        ads_ctrl_n = 1'b0; gw_n = 1'b0; addr = AW'(14); dq_in = pat(14, 30);
        step();
        ads_ctrl_n = 1'b1; gw_n = 1'b1;
        step();
        chk("R12 still released in sleep", DW'(dq_oe), DW'(0));
        idle();
        read_check(14, "R12 contents kept");
        chk("R12 old word", ref_mem[14], old);
    endtask

    initial begin
        idle();
        rst = 1'b1; lin_mode = 1'b1; addr = '0; dq_in = '0;
        @(negedge clk);
        t_reset();
        t_global_write();
        t_byte_write();
        t_proc_write();
        t_burst();
        t_deselect();
        t_proc_gated();
        t_async();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule